// File: doc/BRIEF.md
# Cascadable Four-Channel Reload Timer

This peripheral holds four 16-bit up-counters behind one small register bus. Each channel has a stored reload value and a control word. An enabled channel advances on a tick from its own prescaler, which divides the system clock by 1, 64, 256 or 1024. It can also advance once for every overflow of the channel below it. When a counter steps past 0xFFFF it takes the reload value again, so the period is 65536 minus the reload value, counted in ticks.

Cascading joins neighbouring channels into one wider counter. An overflow reaches the channel above in the same clock cycle, so a chain counts exactly like a single long register. Each channel can raise a sticky interrupt flag when it overflows. The flag stays set until software acknowledges it through a write-one-to-clear input. The system interrupt controller and the clock source sit outside this block.

Top module: `quad_reload_timer`

## Requirements
- R1: While reset is high and on the first cycle after it, every interrupt flag is 0 and the read data is 0. All counters, reload values and control words reset to 0.
- R2: A bus write to byte address 4*n with bit 0 clear stores a reload value for channel n and leaves the counter unchanged. Reading 4*n returns the live counter of channel n on bus_rdata one cycle after the address is presented.
- R3: Control bit 7 enables the channel. Writing it from 0 to 1 loads the counter with the reload value on that clock edge and clears the channel's prescaler phase. A disabled channel holds its counter.
- R4: Control bits [1:0] choose the divider: 0 gives 1, 1 gives 64, 2 gives 256 and 3 gives 1024. The first increment after enabling comes exactly that many cycles after the enabling edge.
- R5: A counter that steps while at 0xFFFF overflows and takes the reload value on that edge. A channel therefore overflows every (65536 - reload) * divider cycles.
- R6: On channels 1 to 3, control bit 2 set makes the channel step once for each overflow of channel n-1, in the same cycle as that overflow, and its prescaler is not used.
- R7: Channel 0 ignores control bit 2. It keeps counting on its prescaler, and bit 2 reads back as 0.
- R8: With control bit 6 set, an overflow sets irq[n] on the same edge as the reload. With bit 6 clear, an overflow leaves irq[n] unchanged.
- R9: irq_ack[n] high for one cycle clears irq[n] on the next edge, unless an enabled overflow of channel n occurs in that cycle. In that case the flag stays set.
- R10: Reading byte address 4*n+2 returns the control word with bits 7, 6, 2, 1 and 0 as written and every other bit 0.
- R11: A control write that leaves bit 7 at 1 does not reload the counter, and counting goes on without a gap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 4 | Byte address of the register being accessed |
| bus_we | input | 1 | Write strobe for one cycle |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Registered read data for the address of the previous cycle |
| irq_ack | input | 4 | Write-one-to-clear acknowledge, one bit per channel |
| irq | output | 4 | Sticky interrupt flags, one bit per channel |

## Verification
A write is applied on the clock edge that follows it. The first increment lands N edges after the enabling edge, where N is the divider. An overflow and its interrupt flag appear on the same edge, and bus_rdata shows the counter value from before the sampling edge. A behavioural model in the bench follows the same edges: the bench drives inputs on falling edges, the model updates on rising edges, and bus_rdata and irq are compared with the model at every falling edge. The directed checks count falling edges from the enabling edge to the first set flag, or read a counter a fixed number of edges later, and compare against hand-computed values: 16, 128, 256, 1024, 4 and 19.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  localparam int CTL_EN   = 7;
  localparam int CTL_IEN  = 6;
  localparam int CTL_CASC = 2;
  localparam int PS_W     = 10;

  function automatic int div_limit(input logic [1:0] sel);
    int sh;
    case (sel)
      2'd0:    sh = 0;
      2'd1:    sh = 6;
      2'd2:    sh = 8;
      default: sh = 10;
    endcase
    return 1 << sh;
  endfunction
endpackage

// File: rtl/tmr_prescaler.sv
module tmr_prescaler
  import tmr_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       run,
  input  logic       restart,
  input  logic [1:0] sel,
  output logic       tick
);
  logic [PS_W-1:0] phase_q;
  logic [PS_W-1:0] last_phase;

  always_comb begin
    last_phase = PS_W'(div_limit(sel) - 1);
    tick       = (phase_q == last_phase);
  end

  always_ff @(posedge clk) begin
    if (rst || restart) begin
      phase_q <= '0;
    end else if (run) begin
      phase_q <= tick ? '0 : phase_q + 1'b1;
    end
  end
endmodule

// File: rtl/tmr_channel.sv
module tmr_channel
  import tmr_pkg::*;
#(
  parameter int CNT_W    = 16,
  parameter bit HAS_CASC = 1'b1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             data_we,
  input  logic             ctrl_we,
  input  logic [CNT_W-1:0] wdata,
  input  logic             casc_in,
  input  logic             irq_ack,
  output logic [CNT_W-1:0] cnt_q,
  output logic [CNT_W-1:0] reload_q,
  output logic [CNT_W-1:0] ctrl_rd,
  output logic             ovf,
  output logic             irq_q,
  output logic             en_q,
  output logic             ien_q
);
  logic       casc_q;
  logic [1:0] div_q;
  logic       en_rise;
  logic       ps_tick;
  logic       step;

  assign en_rise = ctrl_we && wdata[CTL_EN] && !en_q;

  tmr_prescaler u_ps (
    .clk     (clk),
    .rst     (rst),
    .run     (en_q),
    .restart (en_rise),
    .sel     (div_q),
    .tick    (ps_tick)
  );

  generate
    if (HAS_CASC) begin : g_casc
      always_ff @(posedge clk) begin
        if (rst)          casc_q <= 1'b0;
        else if (ctrl_we) casc_q <= wdata[CTL_CASC];
      end
    end else begin : g_nocasc
      assign casc_q = 1'b0;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q  <= 1'b0;
      ien_q <= 1'b0;
      div_q <= 2'd0;
    end else if (ctrl_we) begin
      en_q  <= wdata[CTL_EN];
      ien_q <= wdata[CTL_IEN];
      div_q <= wdata[1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (rst)          reload_q <= '0;
    else if (data_we) reload_q <= wdata;
  end

  always_comb begin
    step = en_q && (casc_q ? casc_in : ps_tick);
    ovf  = step && (cnt_q == {CNT_W{1'b1}});
  end

  always_ff @(posedge clk) begin
    if (rst)          cnt_q <= '0;
    else if (en_rise) cnt_q <= reload_q;
    else if (ovf)     cnt_q <= reload_q;
    else if (step)    cnt_q <= cnt_q + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) irq_q <= 1'b0;
    else     irq_q <= (irq_q && !irq_ack) || (ovf && ien_q);
  end

  always_comb begin
    ctrl_rd           = '0;
    ctrl_rd[CTL_EN]   = en_q;
    ctrl_rd[CTL_IEN]  = ien_q;
    ctrl_rd[CTL_CASC] = casc_q;
    ctrl_rd[1:0]      = div_q;
  end
endmodule

// File: rtl/quad_reload_timer.sv
module quad_reload_timer
  import tmr_pkg::*;
#(
  parameter int NUM_CH  = 4,
  parameter int CNT_W   = 16,
  localparam int ADDR_W = $clog2(NUM_CH) + 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_we,
  input  logic [CNT_W-1:0]  bus_wdata,
  output logic [CNT_W-1:0]  bus_rdata,
  input  logic [NUM_CH-1:0] irq_ack,
  output logic [NUM_CH-1:0] irq
);
  localparam int IDX_W = ADDR_W - 2;

  logic [CNT_W-1:0]        cnt_arr  [NUM_CH];
  logic [CNT_W-1:0]        rel_arr  [NUM_CH];
  logic [CNT_W-1:0]        ctl_arr  [NUM_CH];
  logic [NUM_CH-1:0]       ovf_vec;
  logic [NUM_CH-1:0]       en_vec;
  logic [NUM_CH-1:0]       ien_vec;
  logic [NUM_CH*CNT_W-1:0] cnt_flat;
  logic [NUM_CH*CNT_W-1:0] rel_flat;
  logic [IDX_W-1:0]        sel_ch;
  logic                    aligned;

  assign sel_ch  = bus_addr[ADDR_W-1:2];
  assign aligned = !bus_addr[0];

  generate
    for (genvar n = 0; n < NUM_CH; n++) begin : g_ch
      logic hit;
      logic casc_src;
      assign hit = bus_we && aligned && (sel_ch == IDX_W'(n));
      if (n == 0) begin : g_first
        assign casc_src = 1'b0;
      end else begin : g_upper
        assign casc_src = ovf_vec[n-1];
      end

      tmr_channel #(
        .CNT_W    (CNT_W),
        .HAS_CASC (n != 0)
      ) u_ch (
        .clk      (clk),
        .rst      (rst),
        .data_we  (hit && !bus_addr[1]),
        .ctrl_we  (hit && bus_addr[1]),
        .wdata    (bus_wdata),
        .casc_in  (casc_src),
        .irq_ack  (irq_ack[n]),
        .cnt_q    (cnt_arr[n]),
        .reload_q (rel_arr[n]),
        .ctrl_rd  (ctl_arr[n]),
        .ovf      (ovf_vec[n]),
        .irq_q    (irq[n]),
        .en_q     (en_vec[n]),
        .ien_q    (ien_vec[n])
      );

      assign cnt_flat[n*CNT_W +: CNT_W] = cnt_arr[n];
      assign rel_flat[n*CNT_W +: CNT_W] = rel_arr[n];
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst)               bus_rdata <= '0;
    else if (!aligned)     bus_rdata <= '0;
    else if (bus_addr[1])  bus_rdata <= ctl_arr[sel_ch];
    else                   bus_rdata <= cnt_arr[sel_ch];
  end
endmodule

// File: rtl/tmr_checker.sv
module tmr_checker #(
  parameter int NUM_CH = 4,
  parameter int CNT_W  = 16
) (
  input logic                    clk,
  input logic                    rst,
  input logic [NUM_CH-1:0]       irq,
  input logic [NUM_CH-1:0]       irq_ack,
  input logic [NUM_CH-1:0]       ovf_vec,
  input logic [NUM_CH-1:0]       en_vec,
  input logic [NUM_CH-1:0]       ien_vec,
  input logic [NUM_CH*CNT_W-1:0] cnt_flat,
  input logic [NUM_CH*CNT_W-1:0] rel_flat
);
  AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (rst)
    (irq_ack != '0) |=> ((irq & $past(irq_ack) & ~$past(ovf_vec & ien_vec)) == '0)); // R9

  AST_IRQ_CAUSE: assert property (@(posedge clk) disable iff (rst)
    ((irq & ~$past(irq) & ~$past(ovf_vec & ien_vec)) == '0)); // R8

  generate
    for (genvar n = 0; n < NUM_CH; n++) begin : g_chk
      AST_RELOAD_ON_OVF: assert property (@(posedge clk) disable iff (rst)
        ovf_vec[n] |=> (cnt_flat[n*CNT_W +: CNT_W] == $past(rel_flat[n*CNT_W +: CNT_W]))); // R5

      AST_DISABLED_HOLDS: assert property (@(posedge clk) disable iff (rst)
        !en_vec[n] |=> (en_vec[n] || $stable(cnt_flat[n*CNT_W +: CNT_W]))); // R3
    end
  endgenerate
endmodule

bind quad_reload_timer tmr_checker #(
  .NUM_CH (NUM_CH),
  .CNT_W  (CNT_W)
) u_tmr_checker (
  .clk      (clk),
  .rst      (rst),
  .irq      (irq),
  .irq_ack  (irq_ack),
  .ovf_vec  (ovf_vec),
  .en_vec   (en_vec),
  .ien_vec  (ien_vec),
  .cnt_flat (cnt_flat),
  .rel_flat (rel_flat)
);

// File: tb/tb_quad_reload_timer.sv
module tb_quad_reload_timer;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [3:0]  bus_addr = '0;
  logic        bus_we = 1'b0;
  logic [15:0] bus_wdata = '0;
  logic [15:0] bus_rdata;
  logic [3:0]  irq_ack = '0;
  logic [3:0]  irq;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2 clk = ~clk;

  quad_reload_timer dut (
    .clk       (clk),
    .rst       (rst),
    .bus_addr  (bus_addr),
    .bus_we    (bus_we),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .irq_ack   (irq_ack),
    .irq       (irq)
  );

  // behavioural reference model
  int m_cnt[4], m_rel[4], m_en[4], m_ien[4], m_casc[4], m_div[4], m_pc[4], m_irq[4];
  int m_rd;

  function automatic int lim_of(int sel);
    return (sel == 0) ? 1 : (sel == 1) ? 64 : (sel == 2) ? 256 : 1024;
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      for (int n = 0; n < 4; n++) begin
        m_cnt[n] = 0; m_rel[n] = 0; m_en[n] = 0; m_ien[n] = 0;
        m_casc[n] = 0; m_div[n] = 0; m_pc[n] = 0; m_irq[n] = 0;
      end
      m_rd = 0;
    end else begin
      int ch;
      int ov[4];
      ch = bus_addr >> 2;
      if (bus_addr[0]) m_rd = 0;
      else if (bus_addr[1])
        m_rd = (m_en[ch] << 7) | (m_ien[ch] << 6) | (m_casc[ch] << 2) | m_div[ch];
      else m_rd = m_cnt[ch];
      for (int n = 0; n < 4; n++) begin
        int pt, t;
        ov[n] = 0;
        if (m_en[n] != 0) begin
          pt = (m_pc[n] == lim_of(m_div[n]) - 1) ? 1 : 0;
          m_pc[n] = pt ? 0 : m_pc[n] + 1;
          t = (n > 0 && m_casc[n] != 0) ? ov[n-1] : pt;
          if (t != 0) begin
            if (m_cnt[n] == 65535) begin
              ov[n] = 1;
              m_cnt[n] = m_rel[n];
            end else m_cnt[n] = m_cnt[n] + 1;
          end
        end
        m_irq[n] = ((m_irq[n] != 0 && !irq_ack[n]) || (ov[n] != 0 && m_ien[n] != 0)) ? 1 : 0;
      end
      if (bus_we && !bus_addr[0]) begin
        if (bus_addr[1]) begin
          if (bus_wdata[7] && m_en[ch] == 0) begin
            m_cnt[ch] = m_rel[ch];
            m_pc[ch] = 0;
          end
          m_en[ch] = bus_wdata[7];
          m_ien[ch] = bus_wdata[6];
          m_casc[ch] = (ch > 0) ? int'(bus_wdata[2]) : 0;
          m_div[ch] = bus_wdata[1:0];
        end else m_rel[ch] = bus_wdata;
      end
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // per-cycle comparison against the model, away from the rising edge
  always @(negedge clk) begin
    if (!rst && !done) begin
      chk("R2 bus_rdata vs model", bus_rdata, m_rd);
      chk("R8 irq vs model", irq, (m_irq[3] << 3) | (m_irq[2] << 2) | (m_irq[1] << 1) | m_irq[0]);
    end
  end

  task automatic finish_sim();
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    finish_sim();
  end

  task automatic wr(input int addr, input int data);
    @(negedge clk);
    bus_addr = addr[3:0]; bus_wdata = data[15:0]; bus_we = 1'b1;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic ack_all();
    @(negedge clk);
    irq_ack = 4'hF;
    @(negedge clk);
    irq_ack = 4'h0;
  endtask

  task automatic wait_irq(input int bitn, output int n);
    n = 0;
    while (!irq[bitn] && n < 3000) begin
      @(negedge clk);
      n++;
    end
  endtask

  initial begin
    int n;
    int a;
    repeat (3) @(negedge clk);
    chk("R1 irq during reset", irq, 0);
    chk("R1 rdata during reset", bus_rdata, 0);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 irq after reset", irq, 0);
    chk("R1 rdata after reset", bus_rdata, 0);

    // channel 0, divide by 1, reload FFF0, irq on
    wr(0, 16'hFFF0);
    wr(2, 16'h00C0);
    bus_addr = 4'd0;
    wait_irq(0, n);
    chk("R5 div1 first overflow cycles", n, 16);
    irq_ack = 4'h1;
    @(negedge clk);
    irq_ack = 4'h0;
    chk("R9 ack clears irq0", irq[0], 0);
    wait_irq(0, n);
    chk("R5 second period cycles", n, 15);
    // disabled channel holds its counter
    wr(2, 16'h0000);
    bus_addr = 4'd0;
    repeat (2) @(negedge clk);
    a = bus_rdata;
    repeat (10) @(negedge clk);
    chk("R3 disabled counter holds", bus_rdata, a);
    ack_all();

    // channel 1, divide by 64, reload FFFE
    wr(4, 16'hFFFE);
    wr(6, 16'h00C1);
    wait_irq(1, n);
    chk("R4 div64 overflow cycles", n, 128);

    // cascade: ch1 overflows each cycle, ch2 counts its overflows
    wr(6, 16'h0000);
    wr(4, 16'hFFFF);
    wr(8, 16'hFFFC);
    wr(10, 16'hFFC4);
    bus_addr = 4'd10;
    @(negedge clk);
    chk("R10 ctrl readback masks bits", bus_rdata, 16'h00C4);
    ack_all();
    wr(6, 16'h0080);
    wait_irq(2, n);
    chk("R6 cascade overflow after four lower overflows", n, 4);
    wr(10, 16'h0000);
    wr(6, 16'h0000);

    // channel 0 with cascade bit set still uses its prescaler
    ack_all();
    wr(0, 16'hFFF8);
    wr(2, 16'h00C4);
    bus_addr = 4'd2;
    wait_irq(0, n);
    chk("R7 ch0 ignores cascade bit", n, 8);
    chk("R7 ch0 cascade bit reads 0", bus_rdata, 16'h00C0);
    wr(2, 16'h0000);

    // channel 3: control rewrite keeps counting without reload
    ack_all();
    wr(12, 16'h0000);
    wr(14, 16'h0080);
    repeat (8) @(negedge clk);
    wr(14, 16'h0080);
    bus_addr = 4'd12;
    repeat (10) @(negedge clk);
    chk("R11 no reload on rewrite", bus_rdata, 19);

    // overflow with irq disabled leaves flag clear
    wr(14, 16'h0000);
    wr(12, 16'hFFFF);
    wr(14, 16'h0080);
    repeat (10) @(negedge clk);
    chk("R8 no irq without bit6", irq[3], 0);

    // divide by 256 and 1024
    wr(14, 16'h0000);
    wr(14, 16'h00C2);
    wait_irq(3, n);
    chk("R4 div256 overflow cycles", n, 256);
    wr(14, 16'h0000);
    ack_all();
    wr(14, 16'h00C3);
    wait_irq(3, n);
    chk("R4 div1024 overflow cycles", n, 1024);
    wr(14, 16'h0000);
    ack_all();
    repeat (4) @(negedge clk);
    finish_sim();
  end
endmodule